// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped supervisory timer. A 32-bit down counter reloads from a programmable reload value. The first time the counter expires, the block raises an interrupt. If that interrupt is still pending at the next expiry and reset generation is allowed, the block raises a system reset request. That request holds until the block itself is reset.

Software programs the block through a single-cycle register port. Each write takes effect on one clock edge, and reads return data combinationally. Setting the interrupt-enable bit starts the timer and cannot be undone. A key-guarded lock protects the configuration against stray writes. A debug-halt input can freeze the count when the stall option is on.

Top module: `wdg_top`

## Requirements
- R1: After reset the reload register and the count both read 0xFFFFFFFF. The control, raw status, masked status and lock registers read 0. `irq` and `sys_rst_req` are low.
- R2: The byte offsets are as follows. Reload is at 0x000, count at 0x004, control at 0x008, interrupt clear at 0x00C, raw status at 0x010 and masked status at 0x014. The test register is at 0x418 and the lock register at 0xC00. Control bit 0 is interrupt enable and control bit 1 is reset enable. Test bit 8 is the stall option. Status and lock use bit 0. Reload, control and test read back what was accepted.
- R3: A control write with bit 0 set, made while the interrupt enable is off, loads the count from the reload register on that edge. From the next edge on, the count falls by one per clock. A later control write cannot clear the interrupt enable.
- R4: When the running count is 0 at an edge, that edge sets the raw status and reloads the count from the reload register. The first expiry therefore comes reload+1 edges after the enabling edge.
- R5: An expiry that finds the raw status already set, with reset enable on, asserts `sys_rst_req`. The request stays high until `rst_n` is asserted.
- R6: With reset enable off, repeated expiries never assert `sys_rst_req`.
- R7: Any write to offset 0x00C clears the raw status. The count keeps running, and the next expiry is treated as a first expiry.
- R8: A reload-register write while the timer runs also loads the count with the new value on that edge, and the raw status is left set. While the timer is stopped, a reload write leaves the count unchanged.
- R9: Writing the lock register with 0x1ACCE551 unlocks. Writing any other value locks. The lock reads 1 while locked and 0 while unlocked. While locked, writes to reload, control, interrupt clear and test are ignored.
- R10: The count holds while both the stall option and `dbg_halt` are set. With either one clear, it keeps counting.
- R11: The masked status and `irq` equal the raw status ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| dbg_halt | input | 1 | Processor halted in debug |
| irq | output | 1 | Interrupt request (masked status) |
| sys_rst_req | output | 1 | System reset request, sticky |
| ris | output | 1 | Raw expiry status |
| mis | output | 1 | Masked expiry status |

## Verification
The assertions assume that `dbg_halt`, `wr_en`, `addr` and `wdata` change only away from the rising clock edge and hold steady across it. They also assume that at most one register access is made per cycle. The bench drives every input on the falling edge, one write per cycle, and raises `dbg_halt` only between edges. It never issues a clear write on the same edge as an expiry, so the tie rule between the two is never exercised.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned OFS_RELOAD = 'h000;
  localparam int unsigned OFS_COUNT  = 'h004;
  localparam int unsigned OFS_CTRL   = 'h008;
  localparam int unsigned OFS_ICLR   = 'h00C;
  localparam int unsigned OFS_RAW    = 'h010;
  localparam int unsigned OFS_MASKED = 'h014;
  localparam int unsigned OFS_TEST   = 'h418;
  localparam int unsigned OFS_LOCK   = 'hC00;

  localparam int unsigned CTRL_INTEN_BIT = 0;
  localparam int unsigned CTRL_RESEN_BIT = 1;
  localparam int unsigned TEST_STALL_BIT = 8;

  typedef struct packed {
    logic stall;
    logic resen;
    logic inten;
  } wdg_cfg_t;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned     DW  = 32,
  parameter int unsigned     AW  = 12,
  parameter logic [DW-1:0]   KEY = 32'h1ACCE551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] reload_q,
  output wdg_cfg_t      cfg_q,
  output logic          locked_q,
  output logic          reload_take,
  output logic          clr_take,
  output logic          preload
);
  logic          open_wr;
  logic          take_ctrl, take_test, hit_lock;
  logic [DW-1:0] reload_d;
  wdg_cfg_t      cfg_d;
  logic          locked_d;
  logic          reload_en, cfg_en, lock_en;

  assign open_wr     = wr_en && !locked_q;
  assign reload_take = open_wr && (addr == AW'(OFS_RELOAD));
  assign take_ctrl   = open_wr && (addr == AW'(OFS_CTRL));
  assign clr_take    = open_wr && (addr == AW'(OFS_ICLR));
  assign take_test   = open_wr && (addr == AW'(OFS_TEST));
  assign hit_lock    = wr_en && (addr == AW'(OFS_LOCK));
  assign preload     = take_ctrl && wdata[CTRL_INTEN_BIT] && !cfg_q.inten;

  always_comb begin
    reload_d  = reload_q;
    reload_en = 1'b0;
    if (reload_take) begin
      reload_d  = wdata;
      reload_en = 1'b1;
    end
  end

  always_comb begin
    cfg_d  = cfg_q;
    cfg_en = 1'b0;
    if (take_ctrl) begin
      cfg_d.inten = cfg_q.inten | wdata[CTRL_INTEN_BIT];
      cfg_d.resen = wdata[CTRL_RESEN_BIT];
      cfg_en      = 1'b1;
    end
    if (take_test) begin
      cfg_d.stall = wdata[TEST_STALL_BIT];
      cfg_en      = 1'b1;
    end
  end

  always_comb begin
    locked_d = locked_q;
    lock_en  = 1'b0;
    if (hit_lock) begin
      locked_d = (wdata != KEY);
      lock_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '1;
    else if (reload_en) reload_q <= reload_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked_q <= 1'b0;
    else if (lock_en) locked_q <= locked_d;
  end

  a_r3_inten_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.inten |=> cfg_q.inten);

  a_r9_locked_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr == AW'(OFS_RELOAD)) |=> $stable(reload_q));

  a_r9_locked_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr != AW'(OFS_LOCK)) |=> $stable(cfg_q));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic          freeze,
  input  logic          preload,
  input  logic          reload_take,
  input  logic [DW-1:0] new_value,
  input  logic [DW-1:0] reload_q,
  output logic [DW-1:0] cnt_q,
  output logic          expire
);
  logic [DW-1:0] cnt_d;
  logic          cnt_en;
  logic          stepping;

  assign stepping = running && !freeze && !reload_take;
  assign expire   = stepping && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (preload) begin
      cnt_d  = reload_q;
      cnt_en = 1'b1;
    end else if (running && reload_take) begin
      cnt_d  = new_value;
      cnt_en = 1'b1;
    end else if (stepping) begin
      cnt_d  = (cnt_q == '0) ? reload_q : cnt_q - DW'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !freeze && !reload_take && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DW'(1));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !reload_take && !preload) |=> $stable(cnt_q));

  a_r8_idle_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !preload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_seq.sv
module wdg_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_take,
  input  logic resen,
  output logic ris_q,
  output logic rst_req_q
);
  logic ris_d, ris_en;
  logic rst_d, rst_en;

  always_comb begin
    ris_d  = ris_q;
    ris_en = 1'b0;
    if (expire) begin
      ris_d  = 1'b1;
      ris_en = 1'b1;
    end else if (clr_take) begin
      ris_d  = 1'b0;
      ris_en = 1'b1;
    end
  end

  always_comb begin
    rst_d  = rst_req_q;
    rst_en = 1'b0;
    if (expire && ris_q && resen) begin
      rst_d  = 1'b1;
      rst_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ris_q <= 1'b0;
    else if (ris_en) ris_q <= ris_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rst_req_q <= 1'b0;
    else if (rst_en) rst_req_q <= rst_d;
  end

  a_r5_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);

  a_r5_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_q) |-> ($past(ris_q) && $past(resen)));

  a_r4_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ris_q);
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int unsigned   DW  = 32,
  parameter int unsigned   AW  = 12,
  parameter logic [DW-1:0] KEY = 32'h1ACCE551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          dbg_halt,
  output logic          irq,
  output logic          sys_rst_req,
  output logic          ris,
  output logic          mis
);
  logic          rst_n_i;
  logic [DW-1:0] reload_q, cnt_q;
  wdg_cfg_t      cfg_q;
  logic          locked_q, reload_take, clr_take, preload;
  logic          expire, ris_q, rst_req_q, mis_w;

  wdg_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  wdg_regs #(.DW(DW), .AW(AW), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .reload_q(reload_q), .cfg_q(cfg_q), .locked_q(locked_q),
    .reload_take(reload_take), .clr_take(clr_take), .preload(preload)
  );

  wdg_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .running(cfg_q.inten),
    .freeze(cfg_q.stall && dbg_halt), .preload(preload),
    .reload_take(reload_take), .new_value(wdata), .reload_q(reload_q),
    .cnt_q(cnt_q), .expire(expire)
  );

  wdg_seq u_seq (
    .clk(clk), .rst_n(rst_n_i), .expire(expire), .clr_take(clr_take),
    .resen(cfg_q.resen), .ris_q(ris_q), .rst_req_q(rst_req_q)
  );

  assign mis_w       = ris_q && cfg_q.inten;
  assign ris         = ris_q;
  assign mis         = mis_w;
  assign irq         = mis_w;
  assign sys_rst_req = rst_req_q;

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFS_RELOAD): rdata = reload_q;
      AW'(OFS_COUNT):  rdata = cnt_q;
      AW'(OFS_CTRL): begin
        rdata[CTRL_INTEN_BIT] = cfg_q.inten;
        rdata[CTRL_RESEN_BIT] = cfg_q.resen;
      end
      AW'(OFS_RAW):    rdata[0] = ris_q;
      AW'(OFS_MASKED): rdata[0] = mis_w;
      AW'(OFS_TEST):   rdata[TEST_STALL_BIT] = cfg_q.stall;
      AW'(OFS_LOCK):   rdata[0] = locked_q;
      default:         rdata = '0;
    endcase
  end

  a_r11_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> (ris && cfg_q.inten));
endmodule

// File: tb/sim_wdg_top.sv
`timescale 1ns/1ps
module sim_wdg_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        dbg_halt;
  logic        irq, sys_rst_req, ris, mis;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  localparam logic [31:0] KEY = 32'h1ACCE551;

  wdg_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dbg_halt(dbg_halt), .irq(irq), .sys_rst_req(sys_rst_req),
    .ris(ris), .mis(mis)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog expired (all R) act=%0d cycles exp=<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 32'h0000_0010, 32'h0,          8'd2},  // R2 reload write
    '{1'b0, 12'h000, 32'h0,         32'h0000_0010,  8'd2},  // R2 reload readback
    '{1'b0, 12'h004, 32'h0,         32'hFFFF_FFFF,  8'd8},  // R8 stopped: count untouched
    '{1'b1, 12'h418, 32'h0000_0100, 32'h0,          8'd2},
    '{1'b0, 12'h418, 32'h0,         32'h0000_0100,  8'd2},  // R2 stall bit 8
    '{1'b1, 12'h008, 32'h0000_0002, 32'h0,          8'd2},
    '{1'b0, 12'h008, 32'h0,         32'h0000_0002,  8'd2},  // R2 reset enable bit 1
    '{1'b1, 12'hC00, 32'h0000_0000, 32'h0,          8'd9},
    '{1'b0, 12'hC00, 32'h0,         32'h0000_0001,  8'd9},  // R9 locked reads 1
    '{1'b1, 12'h000, 32'h0000_0055, 32'h0,          8'd9},
    '{1'b0, 12'h000, 32'h0,         32'h0000_0010,  8'd9},  // R9 write ignored
    '{1'b1, 12'hC00, KEY,           32'h0,          8'd9},
    '{1'b0, 12'hC00, 32'h0,         32'h0000_0000,  8'd9},  // R9 unlocked reads 0
    '{1'b1, 12'h418, 32'h0000_0000, 32'h0,          8'd9},
    '{1'b0, 12'h418, 32'h0,         32'h0000_0000,  8'd9},  // R9 write accepted again
    '{1'b0, 12'h010, 32'h0,         32'h0000_0000,  8'd11}  // R11 raw status idle
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, e);
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    adv(2);
    rst_n = 1'b1;
    adv(3);
  endtask

  initial begin
    wr_en = 1'b0; addr = '0; wdata = '0; dbg_halt = 1'b0;
    rst_n = 1'b0;
    adv(1);
    do_reset();

    // R1 reset state
    rd(12'h000, 32'hFFFF_FFFF, "R1 reload");
    rd(12'h004, 32'hFFFF_FFFF, "R1 count");
    rd(12'h008, 32'h0, "R1 control");
    rd(12'hC00, 32'h0, "R1 lock");
    rd(12'h014, 32'h0, "R1 masked");
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 sys_rst_req", {31'b0, sys_rst_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else rd(VEC[i].a, VEC[i].e, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R3/R4/R5/R7: two-stage sequence, reload 9, reset enable on
    wr(12'h000, 32'd9);
    rd(12'h004, 32'hFFFF_FFFF, "R8 stopped count kept");
    wr(12'h008, 32'h3);                       // enabling edge E0
    rd(12'h004, 32'd9, "R3 preload on enable");
    adv(8);
    rd(12'h004, 32'd1, "R3 decrement per clock");
    adv(1);
    chk("R4 no expiry before reload+1", {31'b0, ris}, 32'h0);
    adv(1);
    chk("R4 first expiry raw", {31'b0, ris}, 32'h1);
    chk("R11 irq follows masked", {31'b0, irq}, 32'h1);
    rd(12'h014, 32'h1, "R11 masked status");
    rd(12'h004, 32'd9, "R4 reload on expiry");
    chk("R5 no reset on first expiry", {31'b0, sys_rst_req}, 32'h0);
    wr(12'h00C, 32'h0);                       // E0+11
    chk("R7 clear drops raw", {31'b0, ris}, 32'h0);
    chk("R11 irq drops", {31'b0, irq}, 32'h0);
    adv(8);
    chk("R7 still clear at E0+19", {31'b0, ris}, 32'h0);
    adv(1);
    chk("R7 next expiry raises raw", {31'b0, ris}, 32'h1);
    chk("R7 next expiry is a first expiry", {31'b0, sys_rst_req}, 32'h0);
    adv(9);
    chk("R5 no reset before second expiry", {31'b0, sys_rst_req}, 32'h0);
    adv(1);
    chk("R5 reset on second expiry", {31'b0, sys_rst_req}, 32'h1);
    adv(3);
    chk("R5 reset sticky", {31'b0, sys_rst_req}, 32'h1);
    wr(12'h008, 32'h0);
    rd(12'h008, 32'h1, "R3 enable cannot be cleared");

    do_reset();
    chk("R5 reset released by rst_n", {31'b0, sys_rst_req}, 32'h0);

    // R6: reset enable off, reload 4
    wr(12'h000, 32'd4);
    wr(12'h008, 32'h1);                       // E1
    adv(5);
    chk("R4 expiry after reload+1", {31'b0, ris}, 32'h1);
    adv(5);
    chk("R6 second expiry raw stays", {31'b0, ris}, 32'h1);
    adv(3);
    chk("R6 no reset request", {31'b0, sys_rst_req}, 32'h0);

    // R8 reload write while running
    wr(12'h000, 32'd1000);
    rd(12'h004, 32'd1000, "R8 running reload write loads count");
    chk("R8 raw kept after reload write", {31'b0, ris}, 32'h1);
    adv(3);
    rd(12'h004, 32'd997, "R8 counting from new value");

    // R10 stall
    wr(12'h418, 32'h100);
    dbg_halt = 1'b1;
    rd(12'h004, 32'd996, "R10 count at halt");
    adv(5);
    rd(12'h004, 32'd996, "R10 held while halted");
    dbg_halt = 1'b0;
    adv(1);
    rd(12'h004, 32'd995, "R10 resumes after halt");
    wr(12'h418, 32'h0);
    dbg_halt = 1'b1;
    adv(2);
    rd(12'h004, 32'd992, "R10 halt ignored without stall bit");
    dbg_halt = 1'b0;

    // R9 lock blocks clear; R7 clear after unlock
    wr(12'hC00, 32'h5);
    wr(12'h00C, 32'h0);
    chk("R9 locked clear ignored", {31'b0, ris}, 32'h1);
    wr(12'hC00, KEY);
    wr(12'h00C, 32'h0);
    chk("R7 clear after unlock", {31'b0, ris}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule